// File: doc/BRIEF.md
# Programmable PWM Channel Generator

One pulse-width-modulated output channel configured through two 32-bit memory-mapped words. One word holds control and clock division. The other holds the compare points and the period. The core clock is divided twice. The first stage divides by a power of two and the second divides linearly. The resulting tick advances an 8-bit period counter, which runs from 0 up to the programmed period and then wraps. Two compare points, rise and fall, decide when the output is active. While both the clock enable and the pin enable are set, the output period is `2^H * (L+1) * (P+1)` core cycles.

The active level can be inverted. The pin can be driven push-pull, or in open-drain style, where it only pulls low through its output enable. Compare-point updates can be applied at once, or held in a shadow and applied when the counter wraps. Software uses the wrap-synchronised mode to change the duty cycle without producing a runt pulse.

Top module: `pwm_chan`

## Requirements
- R1: Offset 0x0 is the control word. Its fields are: bits 7:0 linear divider L, bits 11:8 power-of-two exponent H, bit 12 pin enable, bit 13 open-drain select, bit 14 invert, bit 16 clock enable, and bit 17 sync disable. Offset 0x4 is the duty word. Its fields are: bits 7:0 rise point, bits 15:8 fall point, and bits 31:24 period P. Unimplemented bits read 0. A write to any other offset changes nothing, and a read of any other offset returns 0.
- R2: While the channel runs, the output period is `2^H * (L+1) * (P+1)` clock cycles.
- R3: The output is active while the count is at least rise and below fall. The active time per period is therefore (number of counts c in 0..P with rise <= c < fall) * `2^H*(L+1)` cycles. When rise equals fall, the output is never active.
- R4: Unless both the clock enable and the pin enable are set, the counter holds at 0 and the pin sits at the idle level, which is the inactive level after inversion.
- R5: With invert set, `pwm_o` is low while the output is active and high while it is inactive. Without invert, `pwm_o` is high while active.
- R6: With open-drain set, `pwm_o` is always 0 and `pwm_oe_o` is the complement of the level: asserted for low, released for high.
- R7: With sync disable clear, new duty-word values take effect only when the counter wraps to 0. A period already under way finishes with the old points.
- R8: With sync disable set, new duty-word values take effect within the period under way.
- R9: After reset, both words read 0, `pwm_o` is 0 and `pwm_oe_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte offset within the channel |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| pwm_o | output | 1 | Output pin level |
| pwm_oe_o | output | 1 | Output pin drive enable |

## Verification
The delicate overlap is a duty-word write that lands while a period is under way, close to the counter position that ends the active phase. The bench writes a new fall point in the cycle right after the output turns active. It then counts how many cycles that same pulse stays active. In sync mode the pulse must end at the old fall point and only the following period may use the new one. In immediate mode the stretched pulse must already show in the same period. The divider, period and compare settings are also swept, and each measured period and high time is compared with the formula.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
  localparam int CNT_W  = 8;
  localparam int DIVH_W = 4;
  localparam int DIVL_W = 8;
  localparam int DW     = 32;

  // control word bit positions
  localparam int C_DIVL_LSB = 0;
  localparam int C_DIVH_LSB = 8;
  localparam int C_PIN_EN   = 12;
  localparam int C_OD       = 13;
  localparam int C_INV      = 14;
  localparam int C_CLK_EN   = 16;
  localparam int C_NOSYNC   = 17;

  // duty word bit positions
  localparam int D_RISE_LSB = 0;
  localparam int D_FALL_LSB = 8;
  localparam int D_PER_LSB  = 24;

  typedef struct packed {
    logic [CNT_W-1:0] per;
    logic [CNT_W-1:0] fall;
    logic [CNT_W-1:0] rise;
  } cmp_cfg_t;
endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale
  import pwm_chan_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [DIVH_W-1:0] divh_i,
  input  logic [DIVL_W-1:0] divl_i,
  output logic              tick_o
);
  localparam int PW_W = (1 << DIVH_W) - 1;

  logic [PW_W-1:0]   pw_q;
  logic [PW_W-1:0]   pw_lim;
  logic [DIVL_W-1:0] lin_q;
  logic              tick_h;
  logic              lin_end;

  assign pw_lim  = ~({PW_W{1'b1}} << divh_i);
  assign tick_h  = (pw_q >= pw_lim);
  assign lin_end = (lin_q >= divl_i);
  assign tick_o  = run_i && tick_h && lin_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pw_q  <= '0;
      lin_q <= '0;
    end else if (!run_i) begin
      pw_q  <= '0;
      lin_q <= '0;
    end else begin
      pw_q <= tick_h ? '0 : pw_q + 1'b1;
      if (tick_h) lin_q <= lin_end ? '0 : lin_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_period_cnt.sv
module pwm_period_cnt
  import pwm_chan_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             sync_i,
  input  cmp_cfg_t         shd_i,
  output logic [CNT_W-1:0] cnt_o,
  output cmp_cfg_t         act_o
);
  logic [CNT_W-1:0] cnt_q;
  cmp_cfg_t         act_q;
  logic             wrap;
  logic             load;

  assign wrap = (cnt_q >= act_q.per);
  // shadow copies through when idle, unsynced, or at the wrap tick
  assign load = !run_i || !sync_i || (tick_i && wrap);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= '0;
    end else begin
      if (!run_i)      cnt_q <= '0;
      else if (tick_i) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      if (load) act_q <= shd_i;
    end
  end

  assign cnt_o = cnt_q;
  assign act_o = act_q;

  AST_WRAP_TO_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && cnt_q >= act_q.per) |=> (cnt_q == '0)); // R2
  AST_STOP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0)); // R4
  AST_HOLD_POINTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && sync_i && !tick_i) |=> $stable(act_q)); // R7
endmodule

// File: rtl/pwm_shaper.sv
module pwm_shaper
  import pwm_chan_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  cmp_cfg_t         act_i,
  input  logic             inv_i,
  input  logic             od_i,
  output logic             pwm_o,
  output logic             oe_o
);
  logic on;
  logic lvl;
  logic pwm_q, oe_q;

  assign on  = run_i && (cnt_i >= act_i.rise) && (cnt_i < act_i.fall);
  assign lvl = on ^ inv_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwm_q <= 1'b0;
      oe_q  <= 1'b1;
    end else begin
      pwm_q <= od_i ? 1'b0 : lvl;
      oe_q  <= od_i ? ~lvl : 1'b1;
    end
  end

  assign pwm_o = pwm_q;
  assign oe_o  = oe_q;

  AST_OD_NEVER_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    od_i |=> !pwm_o); // R6
  AST_IDLE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !od_i) |=> (pwm_o == $past(inv_i))); // R4
  AST_EQUAL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !od_i && act_i.rise == act_i.fall) |=> (pwm_o == $past(inv_i))); // R3
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_chan_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              pwm_o,
  output logic              pwm_oe_o
);
  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_DUTY = ADDR_W'(4);

  logic [DIVH_W-1:0] divh_q;
  logic [DIVL_W-1:0] divl_q;
  logic              clk_en_q, pin_en_q, inv_q, od_q, nosync_q;
  cmp_cfg_t          shd_q, act;
  logic [CNT_W-1:0]  cnt;
  logic              run, tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      divh_q <= '0; divl_q <= '0;
      clk_en_q <= 1'b0; pin_en_q <= 1'b0;
      inv_q <= 1'b0; od_q <= 1'b0; nosync_q <= 1'b0;
      shd_q <= '0;
    end else if (we_i) begin
      if (addr_i == OFS_CTRL) begin
        divl_q   <= wdata_i[C_DIVL_LSB +: DIVL_W];
        divh_q   <= wdata_i[C_DIVH_LSB +: DIVH_W];
        pin_en_q <= wdata_i[C_PIN_EN];
        od_q     <= wdata_i[C_OD];
        inv_q    <= wdata_i[C_INV];
        clk_en_q <= wdata_i[C_CLK_EN];
        nosync_q <= wdata_i[C_NOSYNC];
      end else if (addr_i == OFS_DUTY) begin
        shd_q.rise <= wdata_i[D_RISE_LSB +: CNT_W];
        shd_q.fall <= wdata_i[D_FALL_LSB +: CNT_W];
        shd_q.per  <= wdata_i[D_PER_LSB +: CNT_W];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == OFS_CTRL) begin
      rdata_o[C_DIVL_LSB +: DIVL_W] = divl_q;
      rdata_o[C_DIVH_LSB +: DIVH_W] = divh_q;
      rdata_o[C_PIN_EN] = pin_en_q;
      rdata_o[C_OD]     = od_q;
      rdata_o[C_INV]    = inv_q;
      rdata_o[C_CLK_EN] = clk_en_q;
      rdata_o[C_NOSYNC] = nosync_q;
    end else if (addr_i == OFS_DUTY) begin
      rdata_o[D_RISE_LSB +: CNT_W] = shd_q.rise;
      rdata_o[D_FALL_LSB +: CNT_W] = shd_q.fall;
      rdata_o[D_PER_LSB +: CNT_W]  = shd_q.per;
    end
  end

  assign run = clk_en_q && pin_en_q;

  pwm_prescale u_pre (
    .clk_i (clk_i), .rst_ni (rst_ni), .run_i (run),
    .divh_i (divh_q), .divl_i (divl_q), .tick_o (tick)
  );

  pwm_period_cnt u_cnt (
    .clk_i (clk_i), .rst_ni (rst_ni), .run_i (run), .tick_i (tick),
    .sync_i (!nosync_q), .shd_i (shd_q), .cnt_o (cnt), .act_o (act)
  );

  pwm_shaper u_shp (
    .clk_i (clk_i), .rst_ni (rst_ni), .run_i (run), .cnt_i (cnt),
    .act_i (act), .inv_i (inv_q), .od_i (od_q),
    .pwm_o (pwm_o), .oe_o (pwm_oe_o)
  );

  AST_RD_ZERO_ELSEWHERE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != OFS_CTRL && addr_i != OFS_DUTY) |-> (rdata_o == '0)); // R1
endmodule

// File: tb/sim_pwm_chan.sv
module sim_pwm_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pwm, oe;
  logic        od_m = 1'b0, inv_m = 1'b0;
  logic        act;
  int          total = 0, bad = 0;
  int          cycles = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  pwm_chan u0 (
    .clk_i (clk), .rst_ni (rst_n), .we_i (we), .addr_i (addr),
    .wdata_i (wdata), .rdata_o (rdata), .pwm_o (pwm), .pwm_oe_o (oe)
  );

  assign act = (od_m ? ~oe : pwm) ^ inv_m;

  task automatic chk(input string req, input longint got, input longint exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; addr = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  function automatic logic [31:0] duty_w(int p, int r, int f);
    return (32'(p) << 24) | (32'(f) << 8) | 32'(r);
  endfunction

  function automatic logic [31:0] ctrl_w(int h, int l, bit en, bit inv, bit od, bit nosync);
    return (32'(nosync) << 17) | (32'(en) << 16) | (32'(inv) << 14) |
           (32'(od) << 13) | (32'(en) << 12) | (32'(h) << 8) | 32'(l);
  endfunction

  task automatic measure(output int per, output int hi);
    logic prev;
    int g;
    g = 0;
    while (act === 1'b1 && g < 5000) begin @(negedge clk); g++; end
    while (act !== 1'b1 && g < 5000) begin @(negedge clk); g++; end
    per = 0; hi = 0;
    forever begin
      if (act) hi++;
      per++;
      prev = act;
      @(negedge clk);
      if (!prev && act) break;
      if (per > 5000) break;
    end
  endtask

  function automatic int on_counts(int p, int r, int f);
    int n = 0;
    for (int c = 0; c <= p; c++) if (c >= r && c < f) n++;
    return n;
  endfunction

  task automatic dup_write(input bit nosync, input int exp_hi);
    int per, hi, g;
    logic [31:0] c;
    c = ctrl_w(0, 0, 1, 0, 0, nosync);
    wr(4'h4, duty_w(15, 0, 4));
    wr(4'h0, c);
    measure(per, hi);
    g = 0;
    while (act === 1'b1 && g < 500) begin @(negedge clk); g++; end
    while (act !== 1'b1 && g < 500) begin @(negedge clk); g++; end
    hi = 1; we = 1'b1; addr = 4'h4; wdata = duty_w(15, 0, 12);
    @(negedge clk); we = 1'b0;
    while (act === 1'b1 && hi < 500) begin hi++; @(negedge clk); end
    if (nosync) chk("R8 high time of pulse in flight", hi, exp_hi);
    else        chk("R7 high time of pulse in flight", hi, exp_hi);
    measure(per, hi);
    chk("R7 R8 next period high", hi, 12);
    chk("R7 R8 next period length", per, 16);
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected<=150000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin : main
    logic [31:0] d;
    int per, hi, bad_px;
    repeat (3) @(negedge clk);
    chk("R9 pwm after reset", pwm, 0);
    chk("R9 oe after reset", oe, 1);
    rst_n = 1'b1;
    rd(4'h0, d); chk("R9 ctrl after reset", d, 0);
    rd(4'h4, d); chk("R9 duty after reset", d, 0);

    // R1 register map
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h4, d); chk("R1 duty readback", d, 32'hFF00_FFFF);
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, d); chk("R1 ctrl readback", d, 32'h0003_7FFF);
    wr(4'h8, 32'h1234_5678);
    rd(4'h8, d); chk("R1 unmapped read", d, 0);
    rd(4'h0, d); chk("R1 ctrl untouched by unmapped write", d, 32'h0003_7FFF);
    wr(4'h0, 32'h0);

    // R2 R3 sweep over dividers and compare points
    for (int h = 0; h < 3; h++)
      for (int l = 0; l < 3; l++)
        for (int k = 0; k < 3; k++) begin
          int r, f, p, sc;
          p = 7;
          r = (k == 0) ? 0 : (k == 1) ? 2 : 5;
          f = (k == 0) ? 3 : (k == 1) ? 6 : 7;
          sc = (1 << h) * (l + 1);
          wr(4'h0, 32'h0);
          wr(4'h4, duty_w(p, r, f));
          wr(4'h0, ctrl_w(h, l, 1, 0, 0, 0));
          measure(per, hi);
          measure(per, hi);
          chk("R2 period", per, sc * (p + 1));
          chk("R3 high time", hi, sc * on_counts(p, r, f));
        end

    // R3 equal compare points
    wr(4'h4, duty_w(7, 3, 3));
    wr(4'h0, ctrl_w(0, 0, 1, 0, 0, 0));
    repeat (4) @(negedge clk);
    bad_px = 0;
    for (int i = 0; i < 64; i++) begin @(negedge clk); if (pwm) bad_px++; end
    chk("R3 equal points never active", bad_px, 0);

    // R5 inversion
    inv_m = 1'b1;
    wr(4'h4, duty_w(7, 0, 3));
    wr(4'h0, ctrl_w(0, 0, 1, 1, 0, 0));
    measure(per, hi); measure(per, hi);
    chk("R5 inverted active time", hi, 3);
    chk("R5 inverted period", per, 8);

    // R4 idle with pin enable clear (inverted idle is high)
    wr(4'h0, ctrl_w(0, 0, 1, 1, 0, 0) & ~32'h0000_1000);
    repeat (2) @(negedge clk);
    bad_px = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (pwm !== 1'b1) bad_px++; end
    chk("R4 idle level with pin off", bad_px, 0);
    wr(4'h0, ctrl_w(0, 0, 1, 0, 0, 0) & ~32'h0001_0000);
    inv_m = 1'b0;
    repeat (2) @(negedge clk);
    bad_px = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (pwm !== 1'b0) bad_px++; end
    chk("R4 idle level with clock off", bad_px, 0);

    // R6 open drain
    od_m = 1'b1;
    wr(4'h4, duty_w(7, 2, 6));
    wr(4'h0, ctrl_w(1, 1, 1, 0, 1, 0));
    measure(per, hi); measure(per, hi);
    chk("R6 open-drain period via oe", per, 32);
    chk("R6 open-drain high via oe", hi, 16);
    bad_px = 0;
    for (int i = 0; i < 64; i++) begin @(negedge clk); if (pwm !== 1'b0) bad_px++; end
    chk("R6 pin data stays low", bad_px, 0);
    od_m = 1'b0;
    wr(4'h0, 32'h0);

    // R7 synced update, R8 immediate update
    dup_write(1'b0, 4);
    wr(4'h0, 32'h0);
    dup_write(1'b1, 12);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule